// File: doc/BRIEF.md
# Pre/Post Reference-Trigger Sample Recorder

This block records a stream of parallel samples into an on-chip circular buffer. An arm pulse puts it into a waiting state. A selectable edge on a start pin then opens the capture. The recorder first gathers a programmed number of history samples. After that it keeps overwriting the oldest history while it watches for a reference event. Once the event arrives it stores a programmed number of further samples and stops.

The reference event can come from several places, picked by a two-bit selector: an edge on a dedicated pin, a one-cycle software pulse, or a masked comparison of each incoming sample against an expected value. The selector can also turn the event off altogether. When the record is complete, a done flag rises and the buffer address of the oldest sample in the record is presented. A synchronous read port then lets the surrounding logic read the record in order, wrapping at the end of the buffer. Exactly one record is captured per arm.

Top module: `acq_recorder`

## Requirements
- R1: A high `arm` at a clock edge restarts the recorder from any state. From the next cycle `ready_for_start` is high and `done` is low, and `ready_for_start` stays high until the start event is seen.
- R2: The start event is an edge on `start_pin`, rising when `start_pol`=0 and falling when `start_pol`=1. An edge is a level change between consecutive cycles, and the level before the first cycle after reset counts as low. Samples are accepted only from the cycle after the start event.
- R3: A sample is stored only when `smp_valid` is high during an accepting phase. Stored samples go to consecutive addresses starting at 0 after each arm, wrapping modulo DEPTH.
- R4: The first `cfg_pre` accepted samples form the history. Any reference event before they are all stored is ignored. With `cfg_pre`=0 the recorder watches for the reference from the start event on.
- R5: `ref_src` encodes the reference source: 0 = none, 1 = `ref_pin` edge (rising when `ref_pol`=0, falling when 1, same edge rule as R2), 2 = `ref_sw` high for a cycle, 3 = pattern match.
- R6: A pattern match occurs on a valid sample for which every bit set in `pat_mask` equals the same bit of `pat_value`. The first matching sample after the history is full is the reference.
- R7: The post-reference count `cfg_post` includes a valid sample present in the reference cycle. With `cfg_post`=0 the record ends at the reference and the sample in that cycle is not stored.
- R8: `done` rises in the cycle after the last record sample is stored. `rec_start_addr` equals (samples stored since arm − (`cfg_pre`+`cfg_post`)) mod DEPTH. The record is the last `cfg_pre`+`cfg_post` stored samples, in order from that address.
- R9: While `done` is high and no arm arrives, nothing more is written, and `done` and `rec_start_addr` hold.
- R10: `rd_data` shows the buffer word at `rd_addr` one clock after the address is applied.
- R11: After reset, `ready_for_start` and `done` are low and `rec_start_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restart pulse; next state waits for the start event |
| cfg_pre | input | ADDR_W+1 | History (pre-reference) sample count |
| cfg_post | input | ADDR_W+1 | Post-reference sample count; sum with cfg_pre in 1..DEPTH |
| start_pol | input | 1 | Start edge: 0 rising, 1 falling |
| start_pin | input | 1 | Start trigger level |
| ref_src | input | 2 | Reference source: 0 none, 1 pin, 2 software, 3 pattern |
| ref_pol | input | 1 | Reference pin edge: 0 rising, 1 falling |
| ref_pin | input | 1 | Reference trigger level |
| ref_sw | input | 1 | Software reference pulse |
| pat_mask | input | DATA_W | Bits taking part in the pattern compare |
| pat_value | input | DATA_W | Expected value for the pattern compare |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Sample word |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | DATA_W | Buffer word, one cycle after rd_addr |
| ready_for_start | output | 1 | Waiting for the start event |
| done | output | 1 | Record complete |
| rec_start_addr | output | ADDR_W | Address of the oldest record sample |

## Verification
Directed runs cover the edge cases of the window. One run uses a falling start edge with software pulses that land inside the history fill, which separates ignored early references from accepted ones. Another uses a zero history with a full-buffer post count, which forces a wrap of the write address. A third uses a full-buffer history with a zero post count under pattern match, which shows whether the matching sample is left out. A run with the source off shows that the recorder never completes and that a new arm still restarts it. Seeded random runs then mix all sources, both polarities and gappy valid streams. After each done, every word of the record is read back and compared with a bench-side list of accepted samples.

// File: rtl/acq_rec_pkg.sv
package acq_rec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_START = 3'd1,
    ST_PRE_FILL   = 3'd2,
    ST_WAIT_REF   = 3'd3,
    ST_POST_FILL  = 3'd4,
    ST_DONE       = 3'd5
  } acq_state_e;

  typedef enum logic [1:0] {
    REF_OFF     = 2'd0,
    REF_PIN     = 2'd1,
    REF_SOFT    = 2'd2,
    REF_PATTERN = 2'd3
  } ref_src_e;

endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic fall_sel,
  output logic evt
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  // one cycle event on the selected transition
  assign evt = fall_sel ? (prev_q & ~lvl) : (~prev_q & lvl);

endmodule

// File: rtl/acq_ref_sel.sv
module acq_ref_sel
  import acq_rec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              [1:0] src,
  input  logic                    pin_evt,
  input  logic                    soft_pulse,
  input  logic                    smp_valid,
  input  logic [DATA_W-1:0]       smp_data,
  input  logic [DATA_W-1:0]       pat_mask,
  input  logic [DATA_W-1:0]       pat_value,
  output logic                    ref_evt
);

  logic [DATA_W-1:0] bit_ok;
  logic              pat_hit;

  // a bit passes when masked out or equal to the expected bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_cmp
    assign bit_ok[g] = ~pat_mask[g] | ~(smp_data[g] ^ pat_value[g]);
  end

  assign pat_hit = smp_valid & (&bit_ok);

  always_comb begin
    case (ref_src_e'(src))
      REF_PIN:     ref_evt = pin_evt;
      REF_SOFT:    ref_evt = soft_pulse;
      REF_PATTERN: ref_evt = pat_hit;
      default:     ref_evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/acq_sdp_ram.sv
module acq_sdp_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_rec_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              start_evt,
  input  logic              ref_evt,
  input  logic              smp_valid,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done,
  output logic              ready,
  output logic [ADDR_W-1:0] rec_start
);

  acq_state_e        state_q, state_n;
  logic [CNT_W-1:0]  pre_q, pre_n;
  logic [CNT_W-1:0]  post_q, post_n;
  logic [ADDR_W-1:0] wptr_q, wptr_n;
  logic [CNT_W-1:0]  rec_len;

  assign rec_len = cfg_pre + cfg_post;
  assign wr_addr = wptr_q;
  assign wptr_n  = wr_en ? wptr_q + ADDR_W'(1) : wptr_q;

  always_comb begin
    state_n = state_q;
    wr_en   = 1'b0;
    pre_n   = pre_q;
    post_n  = post_q;
    case (state_q)
      ST_IDLE: ;
      ST_WAIT_START: begin
        if (start_evt) begin
          pre_n   = '0;
          post_n  = '0;
          state_n = (cfg_pre == '0) ? ST_WAIT_REF : ST_PRE_FILL;
        end
      end
      ST_PRE_FILL: begin
        // reference events are not looked at while history fills
        if (smp_valid) begin
          wr_en = 1'b1;
          pre_n = pre_q + CNT_W'(1);
          if (pre_n == cfg_pre) state_n = ST_WAIT_REF;
        end
      end
      ST_WAIT_REF: begin
        if (ref_evt) begin
          if (cfg_post == '0) begin
            state_n = ST_DONE;
          end else begin
            wr_en   = smp_valid;
            post_n  = smp_valid ? CNT_W'(1) : '0;
            state_n = (smp_valid && cfg_post == CNT_W'(1)) ? ST_DONE : ST_POST_FILL;
          end
        end else begin
          wr_en = smp_valid;
        end
      end
      ST_POST_FILL: begin
        if (smp_valid) begin
          wr_en  = 1'b1;
          post_n = post_q + CNT_W'(1);
          if (post_n == cfg_post) state_n = ST_DONE;
        end
      end
      ST_DONE: ;
      default: state_n = ST_IDLE;
    endcase
    if (arm) begin
      state_n = ST_WAIT_START;
      wr_en   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pre_q     <= '0;
      post_q    <= '0;
      wptr_q    <= '0;
      done      <= 1'b0;
      ready     <= 1'b0;
      rec_start <= '0;
    end else begin
      state_q <= state_n;
      pre_q   <= pre_n;
      post_q  <= post_n;
      wptr_q  <= arm ? '0 : wptr_n;
      done    <= (state_n == ST_DONE);
      ready   <= (state_n == ST_WAIT_START);
      if (state_n == ST_DONE && state_q != ST_DONE)
        rec_start <= ADDR_W'({1'b0, wptr_n} - rec_len);
    end
  end

endmodule

// File: rtl/acq_recorder.sv
module acq_recorder
  import acq_rec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic              start_pol,
  input  logic              start_pin,
  input  logic [1:0]        ref_src,
  input  logic              ref_pol,
  input  logic              ref_pin,
  input  logic              ref_sw,
  input  logic [DATA_W-1:0] pat_mask,
  input  logic [DATA_W-1:0] pat_value,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready_for_start,
  output logic              done,
  output logic [ADDR_W-1:0] rec_start_addr
);

  logic              start_evt;
  logic              ref_pin_evt;
  logic              ref_evt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;

  acq_edge_det u_start_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (start_pin),
    .fall_sel (start_pol),
    .evt      (start_evt)
  );

  acq_edge_det u_ref_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (ref_pin),
    .fall_sel (ref_pol),
    .evt      (ref_pin_evt)
  );

  acq_ref_sel #(.DATA_W(DATA_W)) u_ref_sel (
    .src        (ref_src),
    .pin_evt    (ref_pin_evt),
    .soft_pulse (ref_sw),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .pat_mask   (pat_mask),
    .pat_value  (pat_value),
    .ref_evt    (ref_evt)
  );

  acq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .start_evt (start_evt),
    .ref_evt   (ref_evt),
    .smp_valid (smp_valid),
    .cfg_pre   (cfg_pre),
    .cfg_post  (cfg_post),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .ready     (ready_for_start),
    .rec_start (rec_start_addr)
  );

  acq_sdp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (smp_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/acq_recorder_chk.sv
module acq_recorder_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic              smp_valid,
  input logic              wr_en,
  input logic              ready_for_start,
  input logic              done,
  input logic [ADDR_W-1:0] rec_start_addr
);

  assert_ready_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(ready_for_start && done));

  assert_arm_restart_R1: assert property (@(posedge clk) disable iff (rst)
    arm |=> (ready_for_start && !done));

  assert_no_write_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    ready_for_start |-> !wr_en);

  assert_write_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> smp_valid);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> (done && $stable(rec_start_addr)));

  assert_no_write_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!done && !ready_for_start && rec_start_addr == '0));

endmodule

bind acq_recorder acq_recorder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .arm             (arm),
  .smp_valid       (smp_valid),
  .wr_en           (wr_en),
  .ready_for_start (ready_for_start),
  .done            (done),
  .rec_start_addr  (rec_start_addr)
);

// File: tb/acq_recorder_tb.sv
module acq_recorder_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int EXPN  = 8192;

  localparam int P_IDLE = 0, P_WS = 1, P_PF = 2, P_WR = 3, P_PO = 4, P_DONE = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          arm;
  logic [CW-1:0] cfg_pre, cfg_post;
  logic          start_pol, start_pin;
  logic [1:0]    ref_src;
  logic          ref_pol, ref_pin, ref_sw;
  logic [DW-1:0] pat_mask, pat_value;
  logic          smp_valid;
  logic [DW-1:0] smp_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          ready_for_start, done;
  logic [AW-1:0] rec_start_addr;

  always #4 clk = ~clk;

  acq_recorder #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .arm(arm), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .start_pol(start_pol), .start_pin(start_pin), .ref_src(ref_src),
    .ref_pol(ref_pol), .ref_pin(ref_pin), .ref_sw(ref_sw),
    .pat_mask(pat_mask), .pat_value(pat_value), .smp_valid(smp_valid),
    .smp_data(smp_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ready_for_start(ready_for_start), .done(done),
    .rec_start_addr(rec_start_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench-side configuration, applied at the drive point of each cycle
  int b_pre, b_post, b_src;
  bit b_spol, b_rpol;
  logic [DW-1:0] b_mask, b_val;

  // specification model
  int m_phase, m_cnt, m_acc, m_start;
  bit m_ps, m_pr;
  bit cur_sp, cur_rp;
  logic [DW-1:0] exp_mem [EXPN];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [DW-1:0] d);
    exp_mem[m_acc % EXPN] = d;
    m_acc++;
  endtask

  task automatic close_rec();
    m_phase = P_DONE;
    m_start = (m_acc - (b_pre + b_post)) % DEPTH;
  endtask

  // one clock: check outputs of the previous edge, drive, advance the model
  task automatic cyc(input bit a, input bit v, input logic [DW-1:0] d,
                     input bit sp, input bit rp, input bit sw);
    bit se, re, rev;
    @(negedge clk);
    chk(ready_for_start == (m_phase == P_WS), "R1 ready_for_start", ready_for_start, m_phase == P_WS);
    chk(done == (m_phase == P_DONE), "R8 R9 done", done, m_phase == P_DONE);
    if (m_phase == P_DONE)
      chk(rec_start_addr == AW'(m_start), "R8 R9 rec_start_addr", rec_start_addr, m_start);
    cfg_pre = CW'(b_pre); cfg_post = CW'(b_post); ref_src = 2'(b_src);
    start_pol = b_spol; ref_pol = b_rpol; pat_mask = b_mask; pat_value = b_val;
    arm = a; smp_valid = v; smp_data = d; start_pin = sp; ref_pin = rp; ref_sw = sw;
    se = b_spol ? (m_ps & ~sp) : (~m_ps & sp);
    re = b_rpol ? (m_pr & ~rp) : (~m_pr & rp);
    m_ps = sp; m_pr = rp;
    case (b_src)
      1: rev = re;
      2: rev = sw;
      3: rev = v && (((d ^ b_val) & b_mask) == '0);
      default: rev = 0;
    endcase
    if (a) begin
      m_phase = P_WS; m_acc = 0;
    end else begin
      case (m_phase)
        P_WS: if (se) begin m_cnt = 0; m_phase = (b_pre == 0) ? P_WR : P_PF; end
        P_PF: if (v) begin put(d); m_cnt++; if (m_cnt == b_pre) m_phase = P_WR; end
        P_WR: begin
          if (rev) begin
            if (b_post == 0) close_rec();
            else begin
              m_cnt = 0;
              if (v) begin put(d); m_cnt = 1; end
              if (m_cnt == b_post) close_rec(); else m_phase = P_PO;
            end
          end else if (v) put(d);
        end
        P_PO: if (v) begin put(d); m_cnt++; if (m_cnt == b_post) close_rec(); end
        default: ;
      endcase
    end
    @(posedge clk);
  endtask

  task automatic check_record(input string tag);
    int len = b_pre + b_post;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rd_addr = AW'((m_start + i) % DEPTH);
      @(negedge clk);
      chk(rd_data == exp_mem[(m_acc - len + i) % EXPN], {tag, " R8 R10 record word"},
          rd_data, exp_mem[(m_acc - len + i) % EXPN]);
    end
  endtask

  task automatic run_acq(input int pre, input int post, input int src, input bit spol,
                         input bit rpol, input logic [DW-1:0] mask, input logic [DW-1:0] val,
                         input int maxcyc, input string tag);
    int n;
    b_pre = pre; b_post = post; b_src = src; b_spol = spol; b_rpol = rpol;
    b_mask = mask; b_val = val;
    cyc(1, 0, '0, cur_sp, cur_rp, 0);
    n = 0;
    while (m_phase != P_DONE && n < maxcyc) begin
      if ($urandom % 8 == 0) cur_sp = ~cur_sp;
      if ($urandom % 6 == 0) cur_rp = ~cur_rp;
      cyc(0, ($urandom % 4) != 0, DW'($urandom), cur_sp, cur_rp, ($urandom % 10) == 0);
      n++;
    end
    if (m_phase == P_DONE) begin
      // R9: further samples and triggers must leave the record alone
      for (int k = 0; k < 12; k++) begin
        if ($urandom % 3 == 0) cur_rp = ~cur_rp;
        cyc(0, 1, DW'($urandom), cur_sp, cur_rp, 1);
      end
      check_record(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; arm = 0; cfg_pre = '0; cfg_post = '0; start_pol = 0; start_pin = 0;
    ref_src = '0; ref_pol = 0; ref_pin = 0; ref_sw = 0; pat_mask = '0; pat_value = '0;
    smp_valid = 0; smp_data = '0; rd_addr = '0;
    b_pre = 0; b_post = 1; b_src = 0; b_spol = 0; b_rpol = 0; b_mask = '0; b_val = '0;
    m_phase = P_IDLE; m_cnt = 0; m_acc = 0; m_start = 0; m_ps = 0; m_pr = 0;
    cur_sp = 0; cur_rp = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(ready_for_start == 0, "R11 ready_for_start after reset", ready_for_start, 0);
    chk(done == 0, "R11 done after reset", done, 0);
    chk(rec_start_addr == 0, "R11 rec_start_addr after reset", rec_start_addr, 0);
    @(posedge clk);

    // directed corners
    run_acq(6, 3, 2, 1, 0, '0, '0, 1500, "R2 R4 falling start, soft ref");
    run_acq(0, DEPTH, 1, 0, 0, '0, '0, 1500, "R3 R5 R7 zero history, full post");
    run_acq(DEPTH, 0, 3, 0, 0, 8'h0f, 8'h05, 1500, "R6 R7 full history, pattern, no post");
    run_acq(1, 1, 1, 0, 1, '0, '0, 1500, "R5 falling ref pin");
    run_acq(5, 5, 0, 0, 0, '0, '0, 150, "R1 R5 source off");
    run_acq(1, 0, 2, 0, 0, '0, '0, 1500, "R4 R7 single sample");

    // seeded random trials
    for (int t = 0; t < 40; t++) begin
      int len = 1 + ($urandom % DEPTH);
      int pre = $urandom % (len + 1);
      run_acq(pre, len - pre, 1 + ($urandom % 3), 1'($urandom), 1'($urandom),
              DW'($urandom & $urandom & $urandom), DW'($urandom), 1500, "R3 R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule